// File: doc/BRIEF.md
# Paged Address Stack Engine

This block keeps a last-in, first-out stack of 16-bit return addresses inside one fixed 256-byte page of a byte-wide synchronous memory. It owns an 8-bit stack pointer. It turns single-cycle push and pop requests into pairs of byte accesses on a memory port that carries an address, write data, a write enable and returned read data.

A push stores the value most significant byte first, at the page base plus the pointer, and the low byte at the following location. The pointer then advances by two, so the stack grows upward. A pop does the opposite. It first steps the pointer back by two, then reads both bytes and returns them joined into one 16-bit word with a one-cycle valid pulse. The only flow control is a `ready` output. A request is accepted only in a cycle where `ready` is high. Any request made while the engine is busy is dropped.

Top module: `addr_stack_engine`

## Requirements
- R1: After reset, `stack_ptr` is 0x00, `ready` is 1, `pop_valid` is 0 and `mem_we` is 0.
- R2: A push accepted with pointer S drives a write of bits 15:8 to address 0x0100+S in the first cycle after acceptance. It drives a write of bits 7:0 to 0x0100+((S+1) mod 256) in the second cycle. In the third cycle `stack_ptr` reads (S+2) mod 256 and `ready` is 1.
- R3: A pop accepted with pointer S shows `stack_ptr` = (S-2) mod 256 in the first cycle after acceptance. It reads the new pointer's location in that cycle and the next location in the second. It then returns {first byte, second byte} on `pop_addr`.
- R4: Bits 15:8 of `mem_addr` always equal 0x01.
- R5: The pointer wraps modulo 256. 128 pushes from 0x00 bring it back to 0x00, and a pop at 0x00 leaves it at 0xFE.
- R6: `ready` is low for exactly two cycles after a push is accepted and exactly three after a pop is accepted. Requests made while `ready` is low have no effect on the pointer or the memory port.
- R7: `pop_valid` is a single-cycle pulse in the fourth cycle after a pop is accepted, the same cycle in which `ready` returns high.
- R8: When push and pop are both requested in a ready cycle, only the push is performed.
- R9: `mem_we` is high only in the two write cycles of a push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push request, sampled when ready |
| pop_req | input | 1 | Pop request, sampled when ready |
| push_addr | input | 16 | Address value to store |
| ready | output | 1 | Engine idle, able to take a request |
| pop_addr | output | 16 | Value returned by the last pop |
| pop_valid | output | 1 | One-cycle strobe for `pop_addr` |
| stack_ptr | output | 8 | Current stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read byte, one cycle after address |

## Verification
The bench fills all 128 slots and drains them again. This catches a pointer that does not wrap to zero, and a byte order swapped between store and load, which would return values with their halves exchanged. A pop from an empty stack checks the wrap down to 0xFE; a design that saturated would stay at zero and read the wrong slot. The bench also raises both requests together and pulses requests mid-operation. A design with the wrong priority would shrink the stack, and one that failed to ignore busy requests would move the pointer or start an extra memory access.

// File: rtl/ase_pkg.sv
package ase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_HI,
    ST_POP_LO,
    ST_POP_FIN
  } ase_state_t;
endpackage

// File: rtl/ase_ptr.sv
module ase_ptr #(
  parameter int PTR_W = 8,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_en,
  input  logic             dec_en,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] ptr_next_down
);
  localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);

  assign ptr_next_down = ptr - STEP_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (inc_en) begin
      ptr <= ptr + STEP_V;
    end else if (dec_en) begin
      ptr <= ptr_next_down;
    end
  end
endmodule

// File: rtl/ase_seq.sv
module ase_seq
  import ase_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       push_req,
  input  logic       pop_req,
  output ase_state_t state,
  output logic       take_push,
  output logic       take_pop
);
  ase_state_t state_nx;

  assign take_push = (state == ST_IDLE) && push_req;
  assign take_pop  = (state == ST_IDLE) && pop_req && !push_req;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (take_push)     state_nx = ST_PUSH_HI;
        else if (take_pop) state_nx = ST_POP_HI;
      end
      ST_PUSH_HI: state_nx = ST_PUSH_LO;
      ST_PUSH_LO: state_nx = ST_IDLE;
      ST_POP_HI:  state_nx = ST_POP_LO;
      ST_POP_LO:  state_nx = ST_POP_FIN;
      ST_POP_FIN: state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end
endmodule

// File: rtl/ase_port.sv
module ase_port
  import ase_pkg::*;
#(
  parameter int               BYTE_W = 8,
  parameter int               PTR_W  = 8,
  parameter int               PAGE_W = 8,
  parameter logic [PAGE_W-1:0] PAGE  = 8'h01
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ase_state_t                state,
  input  logic                      take_push,
  input  logic                      take_pop,
  input  logic [2*BYTE_W-1:0]       wr_value,
  input  logic [PTR_W-1:0]          ptr,
  input  logic [PTR_W-1:0]          ptr_down,
  output logic [PAGE_W+PTR_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0]         mem_wdata,
  output logic                      mem_we
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [BYTE_W-1:0] lo_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= {PAGE, {PTR_W{1'b0}}};
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      lo_hold   <= '0;
    end else begin
      mem_we <= 1'b0;
      if (take_push) begin
        mem_addr  <= {PAGE, ptr};
        mem_wdata <= wr_value[2*BYTE_W-1:BYTE_W];
        mem_we    <= 1'b1;
        lo_hold   <= wr_value[BYTE_W-1:0];
      end else if (take_pop) begin
        mem_addr <= {PAGE, ptr_down};
      end else if (state == ST_PUSH_HI) begin
        mem_addr  <= {PAGE, ptr + ONE};
        mem_wdata <= lo_hold;
        mem_we    <= 1'b1;
      end else if (state == ST_POP_HI) begin
        mem_addr <= {PAGE, ptr + ONE};
      end
    end
  end
endmodule

// File: rtl/ase_collect.sv
module ase_collect
  import ase_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  ase_state_t          state,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [2*BYTE_W-1:0] value,
  output logic                valid
);
  logic [BYTE_W-1:0] hi_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_byte <= '0;
      value   <= '0;
      valid   <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (state == ST_POP_LO) begin
        hi_byte <= mem_rdata;
      end
      if (state == ST_POP_FIN) begin
        value <= {hi_byte, mem_rdata};
        valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_stack_engine.sv
module addr_stack_engine
  import ase_pkg::*;
#(
  parameter int                BYTE_W = 8,
  parameter int                PTR_W  = 8,
  parameter int                PAGE_W = 8,
  parameter logic [PAGE_W-1:0] PAGE   = 8'h01,
  localparam int               DATA_W = 2 * BYTE_W,
  localparam int               ADDR_W = PAGE_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] push_addr,
  output logic              ready,
  output logic [DATA_W-1:0] pop_addr,
  output logic              pop_valid,
  output logic [PTR_W-1:0]  stack_ptr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [BYTE_W-1:0] mem_rdata
);
  ase_state_t        state;
  logic              take_push;
  logic              take_pop;
  logic [PTR_W-1:0]  ptr_down;

  assign ready = (state == ST_IDLE);

  ase_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .state     (state),
    .take_push (take_push),
    .take_pop  (take_pop)
  );

  ase_ptr #(.PTR_W(PTR_W), .STEP(DATA_W / BYTE_W)) u_ptr (
    .clk           (clk),
    .rst           (rst),
    .inc_en        (state == ST_PUSH_LO),
    .dec_en        (take_pop),
    .ptr           (stack_ptr),
    .ptr_next_down (ptr_down)
  );

  ase_port #(.BYTE_W(BYTE_W), .PTR_W(PTR_W), .PAGE_W(PAGE_W), .PAGE(PAGE)) u_port (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .take_push (take_push),
    .take_pop  (take_pop),
    .wr_value  (push_addr),
    .ptr       (stack_ptr),
    .ptr_down  (ptr_down),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we)
  );

  ase_collect #(.BYTE_W(BYTE_W)) u_collect (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .mem_rdata (mem_rdata),
    .value     (pop_addr),
    .valid     (pop_valid)
  );
endmodule

// File: rtl/ase_checker.sv
module ase_checker #(
  parameter int                PTR_W  = 8,
  parameter int                PAGE_W = 8,
  parameter logic [PAGE_W-1:0] PAGE   = 8'h01
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    push_req,
  input logic                    pop_req,
  input logic                    ready,
  input logic                    pop_valid,
  input logic [PTR_W-1:0]        stack_ptr,
  input logic [PAGE_W+PTR_W-1:0] mem_addr,
  input logic                    mem_we
);
  localparam logic [PTR_W-1:0] TWO = PTR_W'(2);

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
    mem_addr[PAGE_W+PTR_W-1:PTR_W] == PAGE); // R4

  AST_PUSH_FIRST_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ready && push_req) |=> (mem_we && !ready && mem_addr[PTR_W-1:0] == $past(stack_ptr))); // R2

  AST_POP_STEP_BACK: assert property (@(posedge clk) disable iff (rst)
    (ready && pop_req && !push_req) |=> (stack_ptr == $past(stack_ptr) - TWO)); // R3

  AST_IDLE_HOLDS_PTR: assert property (@(posedge clk) disable iff (rst)
    (ready && !push_req && !pop_req) |=> $stable(stack_ptr)); // R6

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pop_valid |=> !pop_valid); // R7

  AST_VALID_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> ready); // R7

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !ready); // R9

  AST_BOTH_PICKS_PUSH: assert property (@(posedge clk) disable iff (rst)
    (ready && push_req && pop_req) |=> mem_we); // R8
endmodule

bind addr_stack_engine ase_checker #(.PTR_W(PTR_W), .PAGE_W(PAGE_W), .PAGE(PAGE)) u_ase_checker (
  .clk       (clk),
  .rst       (rst),
  .push_req  (push_req),
  .pop_req   (pop_req),
  .ready     (ready),
  .pop_valid (pop_valid),
  .stack_ptr (stack_ptr),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we)
);

// File: tb/test_addr_stack_engine.sv
module test_addr_stack_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_req = 1'b0;
  logic        pop_req = 1'b0;
  logic [15:0] push_addr = '0;
  logic        ready;
  logic [15:0] pop_addr;
  logic        pop_valid;
  logic [7:0]  stack_ptr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_rdata;

  logic [7:0]  ram [256];
  logic [15:0] exp_vals [128];
  logic [7:0]  exp_sp = '0;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[7:0]];
  end

  addr_stack_engine i_addr_stack_engine (
    .clk       (clk),
    .rst       (rst),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .push_addr (push_addr),
    .ready     (ready),
    .pop_addr  (pop_addr),
    .pop_valid (pop_valid),
    .stack_ptr (stack_ptr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_push(input logic [15:0] v, input bit both, input bit poke);
    logic [7:0] s0;
    s0 = exp_sp;
    @(negedge clk);
    push_req = 1'b1; pop_req = both; push_addr = v;
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    // R2 / R4 / R8: high byte written at page 0x01 + S
    chk(mem_we && mem_addr == {8'h01, s0} && mem_wdata == v[15:8] && !ready,
        both ? "R8 push wins" : "R2 high byte", {7'd0, mem_we, mem_addr, mem_wdata},
        {8'd1, 8'h01, s0, v[15:8]});
    if (poke) begin push_req = 1'b1; pop_req = 1'b1; end
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    chk(mem_we && mem_addr == {8'h01, s0 + 8'd1} && mem_wdata == v[7:0] && !ready,
        "R2 low byte", {7'd0, mem_we, mem_addr, mem_wdata}, {8'd1, 8'h01, s0 + 8'd1, v[7:0]});
    @(negedge clk);
    exp_vals[s0[7:1]] = v;
    exp_sp = s0 + 8'd2;
    chk(ready && !mem_we && stack_ptr == exp_sp, "R2 pointer advance R6 ready",
        {ready, mem_we, stack_ptr}, {2'b10, exp_sp});
    if (poke || both) begin
      @(negedge clk);
      chk(ready && !mem_we && stack_ptr == exp_sp, "R6 busy request ignored",
          {ready, mem_we, stack_ptr}, {2'b10, exp_sp});
    end
  endtask

  task automatic do_pop(input bit poke);
    logic [7:0] s1;
    @(negedge clk);
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    s1 = exp_sp - 8'd2;
    exp_sp = s1;
    chk(stack_ptr == s1 && mem_addr == {8'h01, s1} && !mem_we && !ready,
        "R3 first read R9", {mem_we, ready, stack_ptr, mem_addr}, {2'b00, s1, 8'h01, s1});
    if (poke) push_req = 1'b1;
    @(negedge clk);
    push_req = 1'b0;
    chk(mem_addr == {8'h01, s1 + 8'd1} && !mem_we && !ready, "R3 second read",
        {mem_we, ready, mem_addr}, {2'b00, 8'h01, s1 + 8'd1});
    @(negedge clk);
    chk(!ready && !pop_valid && !mem_we, "R6 pop third busy cycle",
        {ready, pop_valid, mem_we}, 3'b000);
    @(negedge clk);
    chk(pop_valid && ready && pop_addr == exp_vals[s1[7:1]], "R3 value R7 strobe",
        {pop_valid, ready, pop_addr}, {2'b11, exp_vals[s1[7:1]]});
    @(negedge clk);
    chk(!pop_valid && stack_ptr == s1, "R7 single pulse", {pop_valid, stack_ptr}, {1'b0, s1});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) ram[a] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values, R4 page
    chk(stack_ptr == 8'h00 && ready && !pop_valid && !mem_we && mem_addr[15:8] == 8'h01,
        "R1 reset state", {stack_ptr, ready, pop_valid, mem_we, mem_addr[15:8]},
        {8'h00, 3'b100, 8'h01});

    for (int i = 0; i < 128; i++) begin
      do_push(16'(i * 16'h0103) ^ 16'hA55A, i == 9, i == 5);
    end
    chk(stack_ptr == 8'h00, "R5 wrap after 128 pushes", stack_ptr, 8'h00);

    for (int i = 0; i < 128; i++) begin
      do_pop(i == 7);
    end
    chk(stack_ptr == 8'h00, "R5 drained to zero", stack_ptr, 8'h00);

    // R5: pop at pointer 0 wraps to 0xFE and reads the top slot
    do_pop(1'b0);
    chk(stack_ptr == 8'hFE, "R5 wrap down", stack_ptr, 8'hFE);

    do_push(16'h1234, 1'b0, 1'b0);
    chk(stack_ptr == 8'h00, "R5 push from FE wraps", stack_ptr, 8'h00);
    do_pop(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule